// File: doc/BRIEF.md
# Single-Precision Base-2 Logarithm Estimator

This block takes a 32-bit single-precision operand and returns a single-precision estimate of log2 of the operand's magnitude. It is built for vector units that need a fast, low-cost logarithm estimate. The result follows a fixed bit-level recipe and is not an IEEE-rounded value. Input and output each carry a valid flag. The datapath has three register stages, so a result appears exactly three clocks after its operand, and a new operand may be accepted on every clock.

Inside the block, the operand is first split into an exponent and a normalized 24-bit mantissa. A denormal operand is normalized with a leading-zero count. The exponent is loaded into a signed fixed-point accumulator with 23 fraction bits. The mantissa is then compared against 2^0.5, 2^0.25 and 2^0.125, in that order. Each time it reaches a threshold, the matching fraction bit is set and the mantissa is divided by that power. The division is done as the upper half of a multiply by a fixed reciprocal constant. A linear term then covers the remainder. Finally the accumulator is renormalized into single-precision format with a second leading-zero count.

Top module: `flog2_est`

## Requirements
- R1: `res_vld` equals `op_vld` delayed by exactly three clock edges. Back-to-back operands give back-to-back results.
- R2: An operand with exponent field 0xFF and a nonzero fraction (NaN) is returned with bit 22 forced to 1. All other bits are unchanged.
- R3: An operand with exponent field 0xFF and a zero fraction (±Inf) is returned unchanged.
- R4: An operand whose low 31 bits are zero (+0 or -0) returns 0xFF800000 (-Inf).
- R5: The sign bit (bit 31) of a finite nonzero operand has no effect. The operand with bit 31 = 1 gives the same result as the operand with bit 31 = 0.
- R6: An exact power of two 2^k (fraction field zero) returns k as an exact single-precision value. So 1.0 gives 0x00000000, 2.0 gives 0x3F800000 and 0.5 gives 0xBF800000.
- R7: A denormal operand (exponent field 0) is normalized by its leading-zero count lz. Its accumulator starts at (-118 - lz)·2^23. The smallest denormal, 0x00000001, gives 0xC3150000 (-149.0).
- R8: A finite nonzero operand gives the bit-exact result of the following sequence.
  - Three conditional reductions are applied in order:
    - threshold 0xB504F3 sets accumulator bit 22 and multiplies the mantissa by 0xB504F334;
    - threshold 0x9837F0 sets bit 21 and multiplies by 0xD744FCCB;
    - threshold 0x8B95C2 sets bit 20 and multiplies by 0xEAC0C6E8.
  - Each multiply keeps the upper 32 bits of the 64-bit product.
  - If the mantissa is then above 0x800000, the upper 32 bits of ((mantissa - 0x800000)·2)·0xB0C7CD3A are added to the accumulator.
  - A zero accumulator gives 0.
  - Otherwise, with lz the leading-zero count of the accumulator's magnitude and d = 8 - lz, the result is sign·2^31 + (d + 126)·2^23 + (magnitude shifted right by d).
- R9: While reset is asserted and on the first cycle after it, `res_vld` is 0 and `res` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operand valid |
| op | input | 32 | Single-precision operand |
| res_vld | output | 1 | Result valid, three cycles after `op_vld` |
| res | output | 32 | Single-precision log2 estimate |

## Verification
The assertions check the following on every cycle: the three-cycle valid latency, the quieting of NaNs, the unchanged pass-through of infinities, the -Inf result for either zero, and the cleared outputs after reset. The bench covers the rest, because it needs a full model of the arithmetic. This includes:
- the arithmetic path through the three reductions and the linear term;
- the denormal normalization;
- the exact integer results for powers of two;
- the sign-blindness of finite operands.

The bench runs a behavioural model on every clock and covers fixed corner operands, mirrored negative operands, denormals and random operands.

// File: rtl/flog2_est.sv
module flog2_est #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_vld,
  input  logic [W-1:0] op,
  output logic         res_vld,
  output logic [W-1:0] res
);
  localparam int MW = 23;
  localparam int LZW = $clog2(W) + 1;
  localparam logic [W-1:0] QBIT   = W'(1) << (MW - 1);
  localparam logic [W-1:0] ONE    = W'(1) << MW;
  localparam logic [W-1:0] NEGINF = 32'hFF80_0000;
  localparam logic [W-1:0] LINK   = 32'hB0C7_CD3A;

  function automatic logic [LZW-1:0] clz(input logic [W-1:0] v);
    logic [LZW-1:0] n;
    logic hit;
    n = LZW'(W);
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n = LZW'(W - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic [W-1:0] mulhi(input logic [W-1:0] a, input logic [W-1:0] b);
    return W'((64'(a) * 64'(b)) >> W);
  endfunction

  // stage 1: classify and normalize
  logic [7:0]     ex;
  logic [MW-1:0]  fr;
  logic [LZW-1:0] lz1;
  logic           spec1;
  logic [W-1:0]   sval1, acc1, man1;

  assign ex    = op[30:23];
  assign fr    = op[MW-1:0];
  assign lz1   = clz({9'd0, fr});
  assign spec1 = (ex == 8'hFF) || (op[30:0] == 31'd0);
  assign sval1 = (ex != 8'hFF) ? NEGINF : ((fr != '0) ? (op | QBIT) : op);

  always_comb begin
    if (ex == 8'd0) begin
      man1 = {9'd0, fr} << (lz1 - LZW'(8));
      acc1 = (32'hFFFF_FF8A - {{(W-LZW){1'b0}}, lz1}) << MW;
    end else begin
      man1 = {8'd0, 1'b1, fr};
      acc1 = ({24'd0, ex} - 32'd127) << MW;
    end
  end

  logic         v1, sp1;
  logic [W-1:0] sv1, a1, m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; sp1 <= 1'b0; sv1 <= '0; a1 <= '0; m1 <= '0;
    end else begin
      v1 <= op_vld; sp1 <= spec1; sv1 <= sval1; a1 <= acc1; m1 <= man1;
    end
  end

  // stage 2: range reductions and linear residual
  localparam logic [W-1:0] THR [3] = '{32'h00B5_04F3, 32'h0098_37F0, 32'h008B_95C2};
  localparam logic [W-1:0] RCP [3] = '{32'hB504_F334, 32'hD744_FCCB, 32'hEAC0_C6E8};

  logic [W-1:0] acc2, man2;

  always_comb begin
    acc2 = a1;
    man2 = m1;
    for (int k = 0; k < 3; k++) begin
      if (man2 >= THR[k]) begin
        acc2 = acc2 | (QBIT >> k);
        man2 = mulhi(man2, RCP[k]);
      end
    end
    if (man2 > ONE)
      acc2 = acc2 + mulhi((man2 - ONE) << 1, LINK);
  end

  logic         v2, sp2;
  logic [W-1:0] sv2, a2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; sp2 <= 1'b0; sv2 <= '0; a2 <= '0;
    end else begin
      v2 <= v1; sp2 <= sp1; sv2 <= sv1; a2 <= acc2;
    end
  end

  // stage 3: renormalize
  logic [W-1:0]   mag, shf, fin;
  logic [LZW-1:0] lz3;

  assign mag = a2[W-1] ? (~a2 + 1'b1) : a2;
  assign lz3 = clz(mag);
  assign shf = (lz3 <= LZW'(8)) ? (mag >> (LZW'(8) - lz3)) : (mag << (lz3 - LZW'(8)));
  assign fin = (a2 == '0) ? '0
             : ({a2[W-1], {(W-1){1'b0}}} + ((32'd134 - {{(W-LZW){1'b0}}, lz3}) << MW) + shf);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= v2;
      res     <= sp2 ? sv2 : fin;
    end
  end
endmodule

module flog2_est_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_vld,
  input logic [31:0] op,
  input logic        res_vld,
  input logic [31:0] res
);
  logic [1:0] since;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end
  assign warm = (since == 2'd3);

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    warm |-> (res_vld == $past(op_vld, 3)));

  assert_nan_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (warm && res_vld && $past(op[30:23], 3) == 8'hFF && $past(op[22:0], 3) != 23'd0)
      |-> (res == ($past(op, 3) | 32'h0040_0000)));

  assert_inf_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && res_vld && $past(op[30:0], 3) == 31'h7F80_0000) |-> (res == $past(op, 3)));

  assert_zero_neginf_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && res_vld && $past(op[30:0], 3) == 31'd0) |-> (res == 32'hFF80_0000));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!res_vld && res == 32'd0));
endmodule

bind flog2_est flog2_est_chk i_chk (
  .clk(clk), .rst(rst), .op_vld(op_vld), .op(op), .res_vld(res_vld), .res(res)
);

// File: tb/test_flog2_est.sv
module test_flog2_est;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_vld = 1'b0;
  logic [31:0] op = 32'd0;
  logic        res_vld;
  logic [31:0] res;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flog2_est i_flog2_est (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op(op), .res_vld(res_vld), .res(res)
  );

  function automatic logic [31:0] model(input logic [31:0] x);
    longint e, f, mant, acc, mag, sh;
    int lz, d, p;
    e = longint'(x[30:23]);
    f = longint'(x[22:0]);
    if (e == 255) return (f != 0) ? (x | 32'h0040_0000) : x;
    if (x[30:0] == 31'd0) return 32'hFF80_0000;
    if (e == 0) begin
      lz = 32;
      for (int i = 0; i < 32; i++) if ((f >> i) & 1) lz = 31 - i;
      mant = f << (lz - 8);
      acc = longint'(-118 - lz) * 8388608;
    end else begin
      mant = f + 8388608;
      acc = (e - 127) * 8388608;
    end
    if (mant >= 64'hB504F3) begin acc += 4194304; mant = (mant * 64'hB504F334) >> 32; end
    if (mant >= 64'h9837F0) begin acc += 2097152; mant = (mant * 64'hD744FCCB) >> 32; end
    if (mant >= 64'h8B95C2) begin acc += 1048576; mant = (mant * 64'hEAC0C6E8) >> 32; end
    if (mant > 8388608) acc += (((mant - 8388608) * 2) * 64'hB0C7CD3A) >> 32;
    if (acc == 0) return 32'd0;
    mag = (acc < 0) ? -acc : acc;
    p = 0;
    for (int i = 0; i < 32; i++) if ((mag >> i) & 1) p = i;
    d = 8 - (31 - p);
    sh = (d >= 0) ? (mag >> d) : (mag << (-d));
    return 32'(((acc < 0) ? 64'h8000_0000 : 64'd0) + longint'(d + 126) * 8388608 + sh);
  endfunction

  function automatic string tag_of(input logic [31:0] x);
    if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? "R2" : "R3";
    if (x[30:0] == 0) return "R4";
    if (x[30:23] == 8'h00) return "R7";
    if (x[31]) return "R5";
    if (x[22:0] == 0) return "R6";
    return "R8";
  endfunction

  logic        pv [3];
  logic [31:0] pin [3];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin pv[i] <= 1'b0; pin[i] <= 32'd0; end
    end else begin
      pv[0] <= op_vld; pin[0] <= op;
      pv[1] <= pv[0];  pin[1] <= pin[0];
      pv[2] <= pv[1];  pin[2] <= pin[1];
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (res_vld !== pv[2]) begin
        fails++;
        $display("FAIL R1 res_vld got %0b exp %0b", res_vld, pv[2]);
      end
      if (pv[2]) begin
        checks++;
        if (res !== model(pin[2])) begin
          fails++;
          $display("FAIL %s op %h got %h exp %h", tag_of(pin[2]), pin[2], res, model(pin[2]));
        end
      end
    end
  end

  task automatic send(input logic [31:0] x);
    @(negedge clk);
    op_vld = 1'b1;
    op = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_vld = 1'b0;
      op = 32'h5A5A_5A5A;
    end
  endtask

  task automatic fixed_check(input logic [31:0] x, input logic [31:0] exp, input string tag);
    send(x);
    idle(1);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b1 || res !== exp) begin
      fails++;
      $display("FAIL %s op %h got %h exp %h", tag, x, res, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res !== 32'd0) begin
      fails++;
      $display("FAIL R9 reset got vld %0b res %h exp 0 00000000", res_vld, res);
    end
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (res_vld !== 1'b0 || res !== 32'd0) begin
      fails++;
      $display("FAIL R9 after reset got vld %0b res %h exp 0 00000000", res_vld, res);
    end

    fixed_check(32'h3F80_0000, 32'h0000_0000, "R6 1.0");
    fixed_check(32'h4000_0000, 32'h3F80_0000, "R6 2.0");
    fixed_check(32'h3F00_0000, 32'hBF80_0000, "R6 0.5");
    fixed_check(32'h4100_0000, 32'h4040_0000, "R6 8.0");
    fixed_check(32'h0000_0001, 32'hC315_0000, "R7 min denormal");
    fixed_check(32'hC000_0000, 32'h3F80_0000, "R5 -2.0");
    fixed_check(32'h8000_0000, 32'hFF80_0000, "R4 -0");
    fixed_check(32'h0000_0000, 32'hFF80_0000, "R4 +0");
    fixed_check(32'h7F80_0001, 32'h7FC0_0001, "R2 NaN");
    fixed_check(32'hFF80_0000, 32'hFF80_0000, "R3 -Inf");
    fixed_check(32'h7F80_0000, 32'h7F80_0000, "R3 +Inf");

    for (int k = -126; k <= 127; k += 9) send({1'b0, 8'(k + 127), 23'd0});
    idle(2);
    for (int i = 0; i < 40; i++) send(32'h0000_0001 << (i % 23));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      send(r);
      if (i % 5 == 0) idle(1);
      send({~r[31], r[30:0]});
    end
    for (int i = 0; i < 50; i++) send({1'b0, 8'd127 + 8'($urandom % 3), 23'($urandom)});
    idle(6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule